// File: doc/BRIEF.md
# Single-Transfer Bus Cycle Master

This block sits between a local requester and a shared on-chip bus of the classic handshake kind. It turns each local request into one bus cycle. A request carries a byte address, write data, byte lane enables, a direction flag and an optional hold flag. The block frames the transfer with a cycle signal and a strobe. It waits for the slave to end the strobe with an acknowledge, an error or a retry. It then hands back one response pulse that carries the captured read data, a status code and the number of retry terminations seen.

The request side is a valid/ready pair. A request is taken on a rising edge where both `req_valid` and `req_ready` are high. `req_ready` is low from the edge that takes a request until the edge that ends its transfer, so a requester that keeps `req_valid` high simply waits. Requests are never queued. The response side has no back-pressure: `rsp_valid` is a single-clock pulse and the consumer must take it in that clock. The bus side is fully registered. Inputs are sampled only on the rising edge. Reset is synchronous and active high.

A request marked with the hold flag drives the bus lock output together with the cycle. After that transfer ends, the block keeps the cycle signal high and keeps ownership of the bus. The next request is then issued with no gap in the cycle. The first request without the hold flag closes the chain once it ends.

Top module: `bus_cycle_master`

## Requirements
- R1: While reset is high and right after it, `bus_cyc`, `bus_stb`, `bus_lock` and `rsp_valid` are low and `req_ready` is high.
- R2: A request accepted on an edge raises `bus_cyc` and `bus_stb` after that edge. The same edge drives `bus_adr` = request address bits [ADDR_W-1:log2(DATA_W/8)], `bus_sel`, `bus_dat_o`, and `bus_we` (1 = write, 0 = read). `bus_stb` is never high without `bus_cyc`.
- R3: While the strobe has no termination, `bus_stb` stays high and address, data, byte enables and direction do not change.
- R4: An acknowledge ends the transfer. The next clock shows `rsp_valid` with status 2'b00, `rsp_rdata` equal to `bus_dat_i` from the acknowledge clock, and strobe low (cycle also low unless the chain is held).
- R5: An error ends the transfer with status 2'b01. Error wins over retry and acknowledge sampled in the same clock.
- R6: A retry below the limit takes the strobe low for exactly one clock with the cycle still high, then reissues the identical request. Retry wins over acknowledge in the same clock.
- R7: With MAX_RETRY reissues already made, a further retry ends the transfer with status 2'b10 and `rsp_retries` = MAX_RETRY+1.
- R8: `rsp_retries` gives the number of retry terminations seen during the transfer (0 for a clean transfer).
- R9: Each accepted request yields exactly one `rsp_valid` pulse, one clock long.
- R10: `req_ready` is low while a transfer is in flight. A request held during that time neither changes the strobed transfer nor starts a later cycle once it is withdrawn.
- R11: A request with `req_lock` = 1 drives `bus_lock` with the cycle. After it ends, `bus_cyc` and `bus_lock` stay high with `bus_stb` low and `req_ready` high. A following request with `req_lock` = 0 runs inside the same unbroken cycle, and `bus_cyc` and `bus_lock` drop after it ends.
- R12: `rsp_rdata` changes only after an acknowledge. A transfer ended by error or exhausted retry returns the previously captured value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write data |
| req_sel | input | DATA_W/8 | Byte lane enables |
| req_write | input | 1 | 1 = write, 0 = read |
| req_lock | input | 1 | Hold the bus after this transfer |
| rsp_valid | output | 1 | One-clock response pulse |
| rsp_status | output | 2 | 00 done, 01 error, 10 retries exhausted |
| rsp_rdata | output | DATA_W | Data captured on the last acknowledge |
| rsp_retries | output | RCNT_W | Retry terminations in this transfer |
| bus_cyc | output | 1 | Cycle frame |
| bus_stb | output | 1 | Transfer strobe |
| bus_we | output | 1 | Write enable |
| bus_lock | output | 1 | Indivisible-cycle marker |
| bus_adr | output | ADDR_W-log2(DATA_W/8) | Word address |
| bus_sel | output | DATA_W/8 | Byte enables |
| bus_dat_o | output | DATA_W | Write data to slave |
| bus_dat_i | input | DATA_W | Read data from slave |
| bus_ack | input | 1 | Normal termination |
| bus_err | input | 1 | Error termination |
| bus_rty | input | 1 | Retry termination |

## Verification
Transfers are run against a scripted slave with zero and several wait states, for reads and writes. Those runs separate correct strobe holding from early or late capture. Retry runs use sequences of one or two retries that end in an acknowledge, and a run of retries that reaches the limit. These show whether the one-clock gap, the reissue and the count are right. Same-clock combinations of error, retry and acknowledge expose the priority order. An error after a good read shows whether read data is held. A request left asserted during a busy transfer, and a locked pair of transfers, check that nothing is queued and that the cycle stays unbroken across the chain.

// File: rtl/bcm_pkg.sv
package bcm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_STROBE = 2'd1,
    ST_GAP    = 2'd2,
    ST_HOLD   = 2'd3
  } bcm_state_e;

  localparam logic [1:0] RSP_OK  = 2'b00;
  localparam logic [1:0] RSP_ERR = 2'b01;
  localparam logic [1:0] RSP_EXH = 2'b10;
endpackage

// File: rtl/bcm_retry_ctr.sv
module bcm_retry_ctr #(
  parameter int MAX_RETRY = 3,
  parameter int CW        = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  input  logic          snap,
  input  logic          snap_rty,
  output logic          at_limit,
  output logic [CW-1:0] report
);
  logic [CW-1:0] cnt_q;
  localparam logic [CW-1:0] LIMIT = CW'(MAX_RETRY);

  assign at_limit = (cnt_q == LIMIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      report <= '0;
    end else begin
      if (clr)      cnt_q <= '0;
      else if (inc) cnt_q <= cnt_q + 1'b1;
      if (snap)     report <= cnt_q + CW'(snap_rty);
    end
  end
endmodule

// File: rtl/bcm_datapath.sv
module bcm_datapath #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SEL_W  = DATA_W / 8,
  parameter int LSB    = $clog2(SEL_W)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic                capture,
  input  logic [ADDR_W-1:0]   in_addr,
  input  logic [DATA_W-1:0]   in_wdata,
  input  logic [SEL_W-1:0]    in_sel,
  input  logic                in_write,
  input  logic [DATA_W-1:0]   in_rdata,
  output logic [ADDR_W-1:LSB] out_adr,
  output logic [DATA_W-1:0]   out_wdata,
  output logic [SEL_W-1:0]    out_sel,
  output logic                out_we,
  output logic [DATA_W-1:0]   out_rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_adr   <= '0;
      out_wdata <= '0;
      out_sel   <= '0;
      out_we    <= 1'b0;
      out_rdata <= '0;
    end else begin
      if (load) begin
        out_adr   <= in_addr[ADDR_W-1:LSB];
        out_wdata <= in_wdata;
        out_sel   <= in_sel;
        out_we    <= in_write;
      end
      if (capture) out_rdata <= in_rdata;
    end
  end
endmodule

// File: rtl/bcm_fsm.sv
module bcm_fsm
  import bcm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic       req_lock,
  input  logic       bus_ack,
  input  logic       bus_err,
  input  logic       bus_rty,
  input  logic       at_limit,
  output logic       req_ready,
  output logic       cyc_q,
  output logic       stb_q,
  output logic       lock_q,
  output logic       rsp_valid_q,
  output logic [1:0] rsp_status_q,
  output logic       load,
  output logic       capture,
  output logic       rty_inc,
  output logic       snap,
  output logic       snap_rty
);
  bcm_state_e state_q;
  logic       hold_q;
  logic       accept, t_err, t_rty, t_ack, finish;
  logic [1:0] fin_status;

  always_comb begin
    req_ready  = (state_q == ST_IDLE) || (state_q == ST_HOLD);
    accept     = req_valid && req_ready;
    t_err      = stb_q && bus_err;
    t_rty      = stb_q && !bus_err && bus_rty;
    t_ack      = stb_q && !bus_err && !bus_rty && bus_ack;
    finish     = t_err || t_ack || (t_rty && at_limit);
    fin_status = t_err ? RSP_ERR : (t_rty ? RSP_EXH : RSP_OK);
    load       = accept;
    capture    = t_ack;
    rty_inc    = t_rty && !at_limit;
    snap       = finish;
    snap_rty   = t_rty;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      cyc_q        <= 1'b0;
      stb_q        <= 1'b0;
      lock_q       <= 1'b0;
      hold_q       <= 1'b0;
      rsp_valid_q  <= 1'b0;
      rsp_status_q <= RSP_OK;
    end else begin
      rsp_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE, ST_HOLD: begin
          if (accept) begin
            state_q <= ST_STROBE;
            cyc_q   <= 1'b1;
            stb_q   <= 1'b1;
            lock_q  <= req_lock;
            hold_q  <= req_lock;
          end
        end
        ST_STROBE: begin
          if (finish) begin
            rsp_valid_q  <= 1'b1;
            rsp_status_q <= fin_status;
            stb_q        <= 1'b0;
            if (hold_q) begin
              state_q <= ST_HOLD;
            end else begin
              state_q <= ST_IDLE;
              cyc_q   <= 1'b0;
              lock_q  <= 1'b0;
            end
          end else if (t_rty) begin
            state_q <= ST_GAP;
            stb_q   <= 1'b0;
          end
        end
        ST_GAP: begin
          state_q <= ST_STROBE;
          stb_q   <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bus_cycle_master.sv
module bus_cycle_master #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int MAX_RETRY = 3,
  localparam int SEL_W    = DATA_W / 8,
  localparam int LSB      = $clog2(SEL_W),
  localparam int RCNT_W   = $clog2(MAX_RETRY + 2)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [SEL_W-1:0]    req_sel,
  input  logic                req_write,
  input  logic                req_lock,
  output logic                rsp_valid,
  output logic [1:0]          rsp_status,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic [RCNT_W-1:0]   rsp_retries,
  output logic                bus_cyc,
  output logic                bus_stb,
  output logic                bus_we,
  output logic                bus_lock,
  output logic [ADDR_W-1:LSB] bus_adr,
  output logic [SEL_W-1:0]    bus_sel,
  output logic [DATA_W-1:0]   bus_dat_o,
  input  logic [DATA_W-1:0]   bus_dat_i,
  input  logic                bus_ack,
  input  logic                bus_err,
  input  logic                bus_rty
);
  logic load, capture, rty_inc, snap, snap_rty, at_limit;

  bcm_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_lock     (req_lock),
    .bus_ack      (bus_ack),
    .bus_err      (bus_err),
    .bus_rty      (bus_rty),
    .at_limit     (at_limit),
    .req_ready    (req_ready),
    .cyc_q        (bus_cyc),
    .stb_q        (bus_stb),
    .lock_q       (bus_lock),
    .rsp_valid_q  (rsp_valid),
    .rsp_status_q (rsp_status),
    .load         (load),
    .capture      (capture),
    .rty_inc      (rty_inc),
    .snap         (snap),
    .snap_rty     (snap_rty)
  );

  bcm_retry_ctr #(.MAX_RETRY(MAX_RETRY), .CW(RCNT_W)) u_retry (
    .clk      (clk),
    .rst      (rst),
    .clr      (load),
    .inc      (rty_inc),
    .snap     (snap),
    .snap_rty (snap_rty),
    .at_limit (at_limit),
    .report   (rsp_retries)
  );

  bcm_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W), .LSB(LSB)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .capture   (capture),
    .in_addr   (req_addr),
    .in_wdata  (req_wdata),
    .in_sel    (req_sel),
    .in_write  (req_write),
    .in_rdata  (bus_dat_i),
    .out_adr   (bus_adr),
    .out_wdata (bus_dat_o),
    .out_sel   (bus_sel),
    .out_we    (bus_we),
    .out_rdata (rsp_rdata)
  );
endmodule

// File: rtl/bcm_checker.sv
module bcm_checker #(
  parameter int AW = 30,
  parameter int DW = 32,
  parameter int SW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic [1:0]    rsp_status,
  input logic [DW-1:0] rsp_rdata,
  input logic          bus_cyc,
  input logic          bus_stb,
  input logic          bus_we,
  input logic          bus_lock,
  input logic [AW-1:0] bus_adr,
  input logic [SW-1:0] bus_sel,
  input logic [DW-1:0] bus_dat_o,
  input logic [DW-1:0] bus_dat_i,
  input logic          bus_ack,
  input logic          bus_err,
  input logic          bus_rty
);
  AST_STB_INSIDE_CYC: assert property (@(posedge clk) disable iff (rst)
    bus_stb |-> bus_cyc); // R2
  AST_ACCEPT_STROBES: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (bus_stb && bus_cyc)); // R2
  AST_STB_HELD: assert property (@(posedge clk) disable iff (rst)
    (bus_stb && !bus_ack && !bus_err && !bus_rty) |=>
      (bus_stb && $stable(bus_adr) && $stable(bus_dat_o) && $stable(bus_sel) && $stable(bus_we))); // R3
  AST_ACK_DONE: assert property (@(posedge clk) disable iff (rst)
    (bus_stb && bus_ack && !bus_err && !bus_rty) |=>
      (rsp_valid && rsp_status == 2'b00 && !bus_stb && rsp_rdata == $past(bus_dat_i))); // R4
  AST_ERR_DONE: assert property (@(posedge clk) disable iff (rst)
    (bus_stb && bus_err) |=> (rsp_valid && rsp_status == 2'b01)); // R5
  AST_RTY_GAP: assert property (@(posedge clk) disable iff (rst)
    (bus_stb && bus_rty) |=> !bus_stb); // R6
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R9
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    bus_stb |-> !req_ready); // R10
  AST_LOCK_INSIDE_CYC: assert property (@(posedge clk) disable iff (rst)
    bus_lock |-> bus_cyc); // R11
  AST_RDATA_HELD: assert property (@(posedge clk) disable iff (rst)
    !(bus_stb && bus_ack && !bus_err && !bus_rty) |=> $stable(rsp_rdata)); // R12
endmodule

bind bus_cycle_master bcm_checker #(
  .AW(ADDR_W - LSB), .DW(DATA_W), .SW(SEL_W)
) u_bcm_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .rsp_status (rsp_status),
  .rsp_rdata  (rsp_rdata),
  .bus_cyc    (bus_cyc),
  .bus_stb    (bus_stb),
  .bus_we     (bus_we),
  .bus_lock   (bus_lock),
  .bus_adr    (bus_adr),
  .bus_sel    (bus_sel),
  .bus_dat_o  (bus_dat_o),
  .bus_dat_i  (bus_dat_i),
  .bus_ack    (bus_ack),
  .bus_err    (bus_err),
  .bus_rty    (bus_rty)
);

// File: tb/bus_cycle_master_tb_top.sv
`timescale 1ns/1ps
module bus_cycle_master_tb_top;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int MR = 3;
  localparam int RW = $clog2(MR + 2);

  localparam int C_ACK = 1, C_ERR = 2, C_RTY = 3, C_ALL = 4, C_RA = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic          req_valid = 1'b0, req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [3:0]    req_sel = '0;
  logic          req_write = 1'b0, req_lock = 1'b0;
  logic          rsp_valid;
  logic [1:0]    rsp_status;
  logic [DW-1:0] rsp_rdata;
  logic [RW-1:0] rsp_retries;
  logic          bus_cyc, bus_stb, bus_we, bus_lock;
  logic [AW-1:2] bus_adr;
  logic [3:0]    bus_sel;
  logic [DW-1:0] bus_dat_o;
  logic [DW-1:0] cur_rd = '0;
  logic          bus_ack = 1'b0, bus_err = 1'b0, bus_rty = 1'b0;

  bus_cycle_master #(.ADDR_W(AW), .DATA_W(DW), .MAX_RETRY(MR)) dut_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_sel(req_sel), .req_write(req_write), .req_lock(req_lock),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_rdata(rsp_rdata), .rsp_retries(rsp_retries),
    .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_we(bus_we), .bus_lock(bus_lock),
    .bus_adr(bus_adr), .bus_sel(bus_sel), .bus_dat_o(bus_dat_o), .bus_dat_i(cur_rd),
    .bus_ack(bus_ack), .bus_err(bus_err), .bus_rty(bus_rty)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  typedef struct {
    logic [1:0]    st;
    logic [DW-1:0] rd;
    int            rt;
    string         req;
  } exp_t;
  exp_t exp_q[$];
  int   slave_q[$];

  logic [AW-1:2] exp_adr;
  logic [DW-1:0] exp_dat;
  logic [3:0]    exp_sel;
  logic          exp_we, exp_lock;
  int            wait_n = 0;
  logic [DW-1:0] last_rd = '0;

  // scripted slave: one termination code popped per strobe
  int wcnt = 0;
  bit responded = 0;
  int gap_ph = 0;
  bit gap_final = 0;
  always @(negedge clk) begin
    bus_ack <= 1'b0; bus_err <= 1'b0; bus_rty <= 1'b0;
    if (gap_ph == 1) begin
      chk(!bus_stb, "R6", "strobe in retry gap", 64'(bus_stb), 0);
      chk(bus_cyc == !gap_final, "R6", "cycle in retry gap", 64'(bus_cyc), 64'(!gap_final));
      gap_ph = gap_final ? 0 : 2;
    end else if (gap_ph == 2) begin
      chk(bus_stb, "R6", "reissue after one-clock gap", 64'(bus_stb), 1);
      gap_ph = 0;
    end
    if (!rst && bus_stb && !responded) begin
      chk(bus_adr == exp_adr, "R3", "bus address", 64'(bus_adr), 64'(exp_adr));
      chk(bus_dat_o == exp_dat && bus_sel == exp_sel && bus_we == exp_we, "R2",
          "data/sel/we", {bus_dat_o, 27'(0), bus_sel, bus_we}, {exp_dat, 27'(0), exp_sel, exp_we});
      chk(bus_lock == exp_lock, "R11", "lock level", 64'(bus_lock), 64'(exp_lock));
      if (wcnt >= wait_n) begin
        int code;
        code = (slave_q.size() > 0) ? slave_q.pop_front() : C_ACK;
        case (code)
          C_ACK: bus_ack <= 1'b1;
          C_ERR: bus_err <= 1'b1;
          C_RTY: bus_rty <= 1'b1;
          C_ALL: begin bus_ack <= 1'b1; bus_err <= 1'b1; bus_rty <= 1'b1; end
          default: begin bus_ack <= 1'b1; bus_rty <= 1'b1; end
        endcase
        if (code == C_RTY || code == C_RA) begin
          gap_ph = 1;
          gap_final = (slave_q.size() == 0);
        end
        responded = 1;
        wcnt = 0;
      end else begin
        wcnt++;
      end
    end else if (!bus_stb) begin
      responded = 0;
    end
  end

  // monitor / scoreboard
  bit prev_rsp = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (rsp_valid && prev_rsp) chk(0, "R9", "response longer than one clock", 1, 0);
      if (rsp_valid) begin
        if (exp_q.size() == 0) begin
          chk(0, "R9", "unexpected response", 64'(rsp_status), 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(rsp_status == e.st, e.req, "status", 64'(rsp_status), 64'(e.st));
          chk(rsp_rdata == e.rd, e.req, "read data", 64'(rsp_rdata), 64'(e.rd));
          chk(int'(rsp_retries) == e.rt, "R8", "retry count", 64'(rsp_retries), 64'(e.rt));
        end
      end
    end
    prev_rsp = rsp_valid;
  end

  task automatic setup(input logic [AW-1:0] a, input logic [DW-1:0] wd, input logic [3:0] s,
                       input logic w, input logic lk, input int wt, input logic [1:0] st,
                       input int rt, input logic [DW-1:0] rd, input string req);
    exp_t e;
    exp_adr = a[AW-1:2]; exp_dat = wd; exp_sel = s; exp_we = w; exp_lock = lk;
    wait_n = wt; cur_rd = rd;
    if (st == 2'b00) last_rd = rd;
    e.st = st; e.rd = last_rd; e.rt = rt; e.req = req;
    exp_q.push_back(e);
    req_addr = a; req_wdata = wd; req_sel = s; req_write = w; req_lock = lk;
  endtask

  task automatic xfer(input logic [AW-1:0] a, input logic [DW-1:0] wd, input logic [3:0] s,
                      input logic w, input logic lk, input int wt, input logic [1:0] st,
                      input int rt, input logic [DW-1:0] rd, input string req);
    while (!req_ready) @(negedge clk);
    setup(a, wd, s, w, lk, wt, st, rt, rd, req);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "R9", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1: reset state
    chk(!bus_cyc && !bus_stb && !bus_lock && !rsp_valid, "R1", "outputs in reset",
        {bus_cyc, bus_stb, bus_lock, rsp_valid}, 0);
    chk(req_ready, "R1", "ready in reset", 64'(req_ready), 1);
    rst = 1'b0;
    @(negedge clk);
    chk(!bus_cyc && !bus_stb && req_ready, "R1", "idle after reset",
        {bus_cyc, bus_stb, req_ready}, 1);

    // R2 R4: write, no wait state, low address bits dropped
    slave_q.push_back(C_ACK);
    xfer(32'h1000_0007, 32'hDEAD_BEEF, 4'b1111, 1'b1, 1'b0, 0, 2'b00, 0, 32'h1111_2222, "R4");
    // R3 R4: read with two wait states
    slave_q.push_back(C_ACK);
    xfer(32'h0000_0ABC, 32'h0, 4'b0011, 1'b0, 1'b0, 2, 2'b00, 0, 32'hCAFE_0001, "R4");
    // R5 R12: error keeps previous read data
    slave_q.push_back(C_ERR);
    xfer(32'h0000_0040, 32'h0, 4'b1000, 1'b0, 1'b0, 1, 2'b01, 0, 32'h5555_AAAA, "R12");
    // R6 R8: two retries then acknowledge
    slave_q.push_back(C_RTY); slave_q.push_back(C_RTY); slave_q.push_back(C_ACK);
    xfer(32'h0000_0100, 32'h0, 4'b1111, 1'b0, 1'b0, 0, 2'b00, 2, 32'h0BAD_F00D, "R6");
    // R7: retries exhausted
    for (int i = 0; i < MR + 1; i++) slave_q.push_back(C_RTY);
    xfer(32'h0000_0200, 32'h77, 4'b0001, 1'b1, 1'b0, 0, 2'b10, MR + 1, 32'h9999_9999, "R7");
    // R6: retry wins over acknowledge in the same clock
    slave_q.push_back(C_RA); slave_q.push_back(C_ACK);
    xfer(32'h0000_0300, 32'h0, 4'b1111, 1'b0, 1'b0, 0, 2'b00, 1, 32'h1234_5678, "R6");
    // R5: error wins over retry and acknowledge
    slave_q.push_back(C_ALL);
    xfer(32'h0000_0400, 32'h0, 4'b1111, 1'b0, 1'b0, 0, 2'b01, 0, 32'h8765_4321, "R5");
    // R5 R8: error after one retry
    slave_q.push_back(C_RTY); slave_q.push_back(C_ERR);
    xfer(32'h0000_0500, 32'h0, 4'b1111, 1'b0, 1'b0, 0, 2'b01, 1, 32'h0, "R5");

    // R10: request held while busy is ignored, not queued
    slave_q.push_back(C_ACK);
    while (!req_ready) @(negedge clk);
    setup(32'h0000_0600, 32'hA5A5_A5A5, 4'b1111, 1'b1, 1'b0, 3, 2'b00, 0, 32'h4242_4242, "R10");
    req_valid = 1'b1;
    @(negedge clk);
    req_addr = 32'h0000_0F00; req_wdata = 32'h0;
    @(negedge clk);
    chk(!req_ready, "R10", "ready while busy", 64'(req_ready), 0);
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!bus_cyc, "R10", "no queued cycle", 64'(bus_cyc), 0);
    end

    // R11: locked chain
    slave_q.push_back(C_ACK);
    xfer(32'h0000_0700, 32'h1, 4'b1111, 1'b1, 1'b1, 0, 2'b00, 0, 32'h0000_0707, "R11");
    chk(bus_cyc && bus_lock && !bus_stb && req_ready, "R11", "held after locked transfer",
        {bus_cyc, bus_lock, bus_stb, req_ready}, 4'b1101);
    repeat (2) @(negedge clk);
    chk(bus_cyc && bus_lock, "R11", "cycle still held", {bus_cyc, bus_lock}, 2'b11);
    slave_q.push_back(C_ACK);
    xfer(32'h0000_0704, 32'h0, 4'b1111, 1'b0, 1'b0, 1, 2'b00, 0, 32'h0000_0808, "R11");
    chk(!bus_cyc && !bus_lock, "R11", "chain closed", {bus_cyc, bus_lock}, 0);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R9", "responses outstanding", 64'(exp_q.size()), 0);
    finish_run();
  end
endmodule